// File: doc/BRIEF.md
# Flash erase command sequence decoder

This block sits beside an asynchronous parallel NOR-flash style write port. It watches the host's write strobes and spots the six-write erase command sequences. Each write is taken on the rising edge of the active-low write strobe, after that strobe has been brought into the system clock domain. One write is taken per strobe. A finished chip-erase sequence gives a one-cycle chip start pulse to the erase engine. A finished sector-erase sequence gives a one-cycle sector start pulse, and with it the sector number taken from the last write's address.

The erase engine reports its phase on a two-bit input, and that phase decides which writes the decoder honours. When the engine is idle, the full sequence logic runs. While a chip erase runs, every write is dropped. While a sector erase actively runs, only the suspend command is passed on. While a sector erase is suspended, only the resume command is passed on. The host supplies no timing and does not preprogram the array: the engine owns all of that. Once an operation starts, the decoder goes back to its idle read-array state and holds no address.

The sequence machine has six states. S_IDLE waits for the first unlock write. S_UNL1 and S_UNL2 follow the first and second unlock writes. S_SETUP follows the set-up write. S_UNL3 and S_UNL4 follow the second pair of unlock writes. Its transitions are as follows. A matching write moves the machine one state forward (IDLE to UNL1, UNL1 to UNL2, UNL2 to SETUP, SETUP to UNL3, UNL3 to UNL4). Any write taken in S_UNL4 ends the sequence and goes back to S_IDLE, starting an erase only if the write is an erase command. A mismatching write in any state after S_IDLE goes back to S_IDLE. A non-idle engine phase forces S_IDLE.

Top module: `erase_cmd_decoder`

## Requirements
- R1: After reset, chip_start, sector_start, suspend_req and resume_req are 0, sector_id is 0 and array_read is 1.
- R2: With eng_phase = 0 (idle), the writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 give exactly one chip_start pulse. The values are hex; only address bits [10:0] are compared. The pulse is high in the fourth clock cycle after the final strobe's rising edge and low in the other cycles.
- R3: With the same five leading writes and a final write of data 30 at any address, sector_start pulses once, at the same point as R2. In that cycle sector_id equals address bits [18:16] of the final write.
- R4: A write that does not match the next expected write returns the machine to S_IDLE and starts nothing. A later correct six-write sequence then works as in R2.
- R5: While eng_phase = 1 (chip erase running), every write is ignored. No pulse is produced, and the machine is idle afterwards: a lone final erase write after the phase returns to 0 starts nothing.
- R6: While eng_phase = 2 (sector erase running), a write of data B0 at any address pulses suspend_req at the R2 point. Any other write, including full erase sequences, produces no pulse.
- R7: While eng_phase = 3 (sector erase suspended), a write of data 30 at any address pulses resume_req at the R2 point. Any other write produces no pulse.
- R8: array_read is 1 exactly when the machine is in S_IDLE and eng_phase is 0. It is back to 1 in the same cycle as the start pulse.
- R9: sector_id is 0 in every cycle in which sector_start is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we_n | input | 1 | Asynchronous active-low write strobe; a write is taken on its rising edge |
| bus_addr | input | 19 | Host address, held stable until the next write |
| bus_data | input | 8 | Host write data, held stable until the next write |
| eng_phase | input | 2 | Engine phase: 0 idle, 1 chip erase, 2 sector erase, 3 sector erase suspended |
| chip_start | output | 1 | One-cycle chip erase start pulse |
| sector_start | output | 1 | One-cycle sector erase start pulse |
| sector_id | output | 3 | Sector number, valid with sector_start, 0 otherwise |
| suspend_req | output | 1 | One-cycle suspend request to the engine |
| resume_req | output | 1 | One-cycle resume request to the engine |
| array_read | output | 1 | High while in the idle read-array state |

## Verification
Every pulse comes through the same path. Two synchroniser flops, one edge-capture flop and one output flop put it in the fourth clock cycle after the strobe's rising edge. The bench releases the strobe just after a falling clock edge. It then samples at the six falling edges that follow. A pulse counts as correct only if it appears at the fourth sample with the expected sector number and is absent from the other five. array_read is combinational from the state, so the bench reads it at the sixth sample, once the machine has settled.

// File: rtl/erase_cmd_pkg.sv
package erase_cmd_pkg;
    localparam int DATA_W     = 8;
    localparam int UNLOCK_W   = 11;

    localparam logic [UNLOCK_W-1:0] ADR_A = 11'h555;
    localparam logic [UNLOCK_W-1:0] ADR_B = 11'h2AA;

    localparam logic [DATA_W-1:0] KEY_A      = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_B      = 8'h55;
    localparam logic [DATA_W-1:0] CMD_SETUP  = 8'h80;
    localparam logic [DATA_W-1:0] CMD_CHIP   = 8'h10;
    localparam logic [DATA_W-1:0] CMD_SECTOR = 8'h30;
    localparam logic [DATA_W-1:0] CMD_SUSP   = 8'hB0;
    localparam logic [DATA_W-1:0] CMD_RESUME = 8'h30;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CHIP = 2'd1,
        PH_SECT = 2'd2,
        PH_SUSP = 2'd3
    } phase_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_UNL1  = 3'd1,
        S_UNL2  = 3'd2,
        S_SETUP = 3'd3,
        S_UNL3  = 3'd4,
        S_UNL4  = 3'd5
    } seq_e;
endpackage

// File: rtl/erase_wr_sync.sv
module erase_wr_sync #(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              evt,
    output logic [ADDR_W-1:0] evt_addr,
    output logic [DATA_W-1:0] evt_data
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] chain;
    logic         prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[TOP-1:0], we_n};
            prev  <= chain[TOP];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt      <= 1'b0;
            evt_addr <= '0;
            evt_data <= '0;
        end else begin
            evt <= chain[TOP] & ~prev;
            if (chain[TOP] & ~prev) begin
                evt_addr <= bus_addr;
                evt_data <= bus_data;
            end
        end
    end

    // one strobe edge cannot yield events in two consecutive cycles (R2)
    assert_single_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
endmodule

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
    import erase_cmd_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int SECT_LSB = 16,
    localparam int SECT_W  = ADDR_W - SECT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [DATA_W-1:0] evt_data,
    input  phase_e            phase,
    output logic              chip_start,
    output logic              sector_start,
    output logic [SECT_W-1:0] sector_id,
    output logic              array_read
);
    seq_e state, state_nx;

    logic at_a, at_b, key_a_w, key_b_w, eng_free, fin_chip, fin_sect;

    always_comb begin
        at_a     = (evt_addr[UNLOCK_W-1:0] == ADR_A);
        at_b     = (evt_addr[UNLOCK_W-1:0] == ADR_B);
        key_a_w  = at_a && (evt_data == KEY_A);
        key_b_w  = at_b && (evt_data == KEY_B);
        eng_free = (phase == PH_IDLE);
        fin_chip = evt && eng_free && (state == S_UNL4) && at_a && (evt_data == CMD_CHIP);
        fin_sect = evt && eng_free && (state == S_UNL4) && (evt_data == CMD_SECTOR);
    end

    always_comb begin
        state_nx = state;
        if (!eng_free) begin
            state_nx = S_IDLE;
        end else if (evt) begin
            unique case (state)
                S_IDLE:  state_nx = key_a_w ? S_UNL1 : S_IDLE;
                S_UNL1:  state_nx = key_b_w ? S_UNL2 : S_IDLE;
                S_UNL2:  state_nx = (at_a && evt_data == CMD_SETUP) ? S_SETUP : S_IDLE;
                S_SETUP: state_nx = key_a_w ? S_UNL3 : S_IDLE;
                S_UNL3:  state_nx = key_b_w ? S_UNL4 : S_IDLE;
                S_UNL4:  state_nx = S_IDLE;
                default: state_nx = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chip_start   <= 1'b0;
            sector_start <= 1'b0;
            sector_id    <= '0;
        end else begin
            chip_start   <= fin_chip;
            sector_start <= fin_sect;
            sector_id    <= fin_sect ? evt_addr[ADDR_W-1:SECT_LSB] : '0;
        end
    end

    assign array_read = (state == S_IDLE) && eng_free;

    // R2 R3: a start only follows the last unlock state, and the machine is then idle
    assert_start_from_unl4_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_start || sector_start) |-> ($past(state) == S_UNL4 && state == S_IDLE));
    assert_one_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chip_start, sector_start}));
    // R5 R6 R7: no start while the engine was busy
    assert_busy_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) != PH_IDLE) |-> !(chip_start || sector_start));
    // R9: sector number only with its pulse
    assert_id_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sector_start |-> (sector_id == '0));
    // R4: a sequence cannot skip ahead from idle
    assert_no_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_IDLE) |-> (state == S_IDLE || state == S_UNL1));
endmodule

// File: rtl/erase_phase_filter.sv
module erase_phase_filter
    import erase_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic [DATA_W-1:0] evt_data,
    input  phase_e            phase,
    output logic              suspend_req,
    output logic              resume_req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            suspend_req <= 1'b0;
            resume_req  <= 1'b0;
        end else begin
            suspend_req <= evt && (phase == PH_SECT) && (evt_data == CMD_SUSP);
            resume_req  <= evt && (phase == PH_SUSP) && (evt_data == CMD_RESUME);
        end
    end

    // R6: suspend is passed on only while a sector erase runs
    assert_susp_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> ($past(phase) == PH_SECT));
    // R7: resume is passed on only while suspended
    assert_resume_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> ($past(phase) == PH_SUSP));
    // R5: nothing passes during a chip erase
    assert_chip_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_CHIP) |-> !(suspend_req || resume_req));
endmodule

// File: rtl/erase_cmd_decoder.sv
module erase_cmd_decoder
    import erase_cmd_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int SECT_LSB    = 16,
    parameter int SYNC_STAGES = 2,
    localparam int SECT_W     = ADDR_W - SECT_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_data,
    input  logic [1:0]        eng_phase,
    output logic              chip_start,
    output logic              sector_start,
    output logic [SECT_W-1:0] sector_id,
    output logic              suspend_req,
    output logic              resume_req,
    output logic              array_read
);
    logic              evt;
    logic [ADDR_W-1:0] evt_addr;
    logic [DATA_W-1:0] evt_data;
    phase_e            phase;

    assign phase = phase_e'(eng_phase);

    erase_wr_sync #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .we_n(we_n),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .evt(evt), .evt_addr(evt_addr), .evt_data(evt_data)
    );

    erase_seq_fsm #(
        .ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .evt_addr(evt_addr), .evt_data(evt_data), .phase(phase),
        .chip_start(chip_start), .sector_start(sector_start),
        .sector_id(sector_id), .array_read(array_read)
    );

    erase_phase_filter u_filt (
        .clk(clk), .rst_n(rst_n), .evt(evt), .evt_data(evt_data),
        .phase(phase), .suspend_req(suspend_req), .resume_req(resume_req)
    );

    // R8: read-array mode excludes every busy phase
    assert_read_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        array_read |-> (eng_phase == 2'd0));
endmodule

// File: tb/tb_erase_cmd_decoder.sv
module tb_erase_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_n = 1'b1;
    logic [18:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic [1:0]  eng_phase = 2'd0;
    logic        chip_start, sector_start, suspend_req, resume_req, array_read;
    logic [2:0]  sector_id;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    erase_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .bus_addr(bus_addr),
        .bus_data(bus_data), .eng_phase(eng_phase),
        .chip_start(chip_start), .sector_start(sector_start),
        .sector_id(sector_id), .suspend_req(suspend_req),
        .resume_req(resume_req), .array_read(array_read)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected vector {chip, sector, id[2:0], susp, resume} at the fourth sample, zeros elsewhere
    task automatic wr(input logic [18:0] a, input logic [7:0] d,
                      input logic [6:0] exp4, input string req, output logic rd_last);
        logic [6:0] got;
        logic [6:0] exp;
        @(negedge clk);
        bus_addr = a;
        bus_data = d;
        we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            got = {chip_start, sector_start, sector_id, suspend_req, resume_req};
            exp = (k == 4) ? exp4 : 7'd0;
            check(req, {1'b0, got}, {1'b0, exp});
        end
        rd_last = array_read;
    endtask

    function automatic logic [7:0] seq_data(input int pos, input bit sect);
        case (pos)
            1, 4:    return 8'hAA;
            2, 5:    return 8'h55;
            3:       return 8'h80;
            default: return sect ? 8'h30 : 8'h10;
        endcase
    endfunction

    function automatic logic [10:0] seq_low(input int pos);
        return (pos == 2 || pos == 5) ? 11'h2AA : 11'h555;
    endfunction

    // six writes; corrupt = 0 for a clean sequence, else position whose data is flipped
    task automatic run_seq(input bit sect, input int sec, input int corrupt,
                           input bit expect_start, input string req, output logic rd_last);
        logic [7:0]  d;
        logic [18:0] a;
        logic [6:0]  e;
        for (int p = 1; p <= 6; p++) begin
            d = seq_data(p, sect);
            if (p == corrupt) d = d ^ 8'h01;
            a = {sec[2:0], 5'd0, seq_low(p)};
            e = 7'd0;
            if (p == 6 && expect_start)
                e = sect ? {2'b01, a[18:16], 2'b00} : 7'b1000000;
            wr(a, d, e, req, rd_last);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic rd;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {1'b0, chip_start, sector_start, sector_id, suspend_req, resume_req}, 8'd0);
        check("R1", {7'd0, array_read}, 8'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 chip erase
        run_seq(1'b0, 0, 0, 1'b1, "R2", rd);
        check("R8", {7'd0, rd}, 8'd1);
        run_seq(1'b0, 6, 0, 1'b1, "R2", rd);

        // R3 sector erase, every sector
        for (int s = 0; s < 8; s++) begin
            run_seq(1'b1, s, 0, 1'b1, "R3", rd);
            check("R8", {7'd0, rd}, 8'd1);
        end

        // R4 corruption at each position, then a clean sequence
        for (int c = 1; c <= 6; c++) begin
            run_seq(c[0], c, c, 1'b0, "R4", rd);
            check("R4", {7'd0, rd}, 8'd1);
            run_seq(1'b0, 2, 0, 1'b1, "R4", rd);
        end

        // R5 chip erase running: all ignored
        eng_phase = 2'd1;
        @(negedge clk);
        check("R8", {7'd0, array_read}, 8'd0);
        run_seq(1'b1, 3, 0, 1'b0, "R5", rd);
        run_seq(1'b0, 1, 0, 1'b0, "R5", rd);
        wr(19'h00555, 8'hB0, 7'd0, "R5", rd);
        wr(19'h00555, 8'h30, 7'd0, "R5", rd);
        eng_phase = 2'd0;
        wr(19'h40555, 8'h30, 7'd0, "R5", rd);
        wr(19'h00555, 8'h10, 7'd0, "R5", rd);
        check("R8", {7'd0, rd}, 8'd1);

        // R6 sector erase running
        eng_phase = 2'd2;
        run_seq(1'b1, 4, 0, 1'b0, "R6", rd);
        check("R8", {7'd0, rd}, 8'd0);
        wr(19'h00555, 8'h30, 7'd0, "R6", rd);
        wr(19'h7ABCD, 8'hB0, 7'b0000010, "R6", rd);
        wr(19'h12345, 8'hB1, 7'd0, "R6", rd);

        // R7 suspended
        eng_phase = 2'd3;
        wr(19'h00000, 8'hB0, 7'd0, "R7", rd);
        wr(19'h00555, 8'hAA, 7'd0, "R7", rd);
        wr(19'h3F0F0, 8'h30, 7'b0000001, "R7", rd);
        run_seq(1'b0, 5, 0, 1'b0, "R7", rd);

        // R8 back to idle, sequence works again; R9 id quiet is in every wr sample
        eng_phase = 2'd0;
        @(negedge clk);
        check("R8", {7'd0, array_read}, 8'd1);
        run_seq(1'b1, 7, 0, 1'b1, "R9", rd);

        // engine becomes busy mid-sequence: sequence abandoned
        wr(19'h00555, 8'hAA, 7'd0, "R5", rd);
        wr(19'h002AA, 8'h55, 7'd0, "R5", rd);
        eng_phase = 2'd1;
        @(negedge clk);
        eng_phase = 2'd0;
        wr(19'h00555, 8'h80, 7'd0, "R5", rd);
        check("R8", {7'd0, rd}, 8'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule